// File: doc/BRIEF.md
# Tile Shape Configuration Controller

This block holds the shape configuration for a bank of two-dimensional tile registers and tracks whether the bank is configured or in its init state. Software builds a 64-byte configuration image in a staging buffer through a write port that takes either one byte or one 32-bit little-endian word per cycle. A commit strobe then validates the staged image and, if it is valid, makes it the active configuration. The active configuration drives the per-tile shape outputs (row count and bytes per row) toward the tile storage.

An image whose palette byte is zero is a request to return to init: the configuration is dropped and a one-cycle clear strobe tells the tile storage to zero every tile. A release strobe has the same effect. A non-zero palette other than 1, a row count above 16, a row length above 64 bytes or a non-zero reserved byte makes the image invalid. Such an image raises a one-cycle fault pulse and leaves the active state untouched. A read port returns the active image one 32-bit word at a time, and returns zeros while the bank is unconfigured.

Top module: `tcfg_ctrl`

## Requirements
- R1: After reset the bank is unconfigured, all shape outputs and tile_used are zero, and fault, load_ok and zero_all are low.
- R2: With wr_wide low, a write stores wr_data[7:0] at staging byte wr_addr. With wr_wide high, it stores wr_data[8k+7:8k] at byte 4*wr_addr[5:2]+k for k=0..3, and wr_addr[1:0] are ignored.
- R3: The image layout is as follows. Byte 0 holds the palette. Bytes 16+2t (low) and 17+2t (high) hold the 16-bit bytes-per-row of tile t. Byte 48+t holds the row count of tile t. A commit of a valid palette-1 image sets configured and the shapes, and pulses load_ok in the cycle after the commit edge.
- R4: A palette-1 image with any non-zero byte outside bytes 0, 16..31 and 48..55 is invalid.
- R5: A palette value other than 0 and 1 is invalid.
- R6: A row count above 16 or a bytes-per-row value above 64 is invalid. While configured, every held shape stays within these limits.
- R7: An invalid commit pulses fault for one cycle and leaves configured, the shapes and the read-back image unchanged.
- R8: A commit with palette 0 enters init and pulses zero_all, whatever the other bytes hold. No fault is raised.
- R9: release_req enters init and pulses zero_all. When it arrives together with commit, release wins and the commit has no effect.
- R10: rd_req with word index rd_word returns bytes 4*rd_word..4*rd_word+3 of the active image, little-endian, on rd_data with rd_valid in the next cycle. Reserved bytes read as zero, and the whole image reads as zero while unconfigured.
- R11: tile_used[t] is high exactly when the bank is configured and tile t has a non-zero row count and a non-zero bytes-per-row.
- R12: fault, load_ok and zero_all are never high together. Each pulse lasts only one cycle per triggering strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Staging buffer write enable |
| wr_wide | input | 1 | 1 = 32-bit word write, 0 = byte write |
| wr_addr | input | 6 | Staging byte address |
| wr_data | input | 32 | Write data, little-endian lanes |
| commit | input | 1 | Validate and apply the staged image |
| release_req | input | 1 | Return to init and clear tiles |
| rd_req | input | 1 | Read one word of the active image |
| rd_word | input | 4 | Word index for the read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| configured | output | 1 | A valid configuration is active |
| tile_rows | output | 40 | Row count per tile, 5 bits each, tile 0 lowest |
| tile_bpr | output | 56 | Bytes per row per tile, 7 bits each, tile 0 lowest |
| tile_used | output | 8 | Tile has a non-empty shape |
| zero_all | output | 1 | One-cycle request to zero all tile data |
| fault | output | 1 | One-cycle invalid-configuration indication |
| load_ok | output | 1 | One-cycle accepted-configuration indication |

## Verification
The assertions take it that commit and release_req are strobes of a single cycle. They also take it that the staging buffer is not written in the same cycle as a commit, so the image that is validated is the one that was written. The bench drives every strobe for exactly one cycle. It writes a full image before each commit and never overlaps a write with a commit or a read. The random images keep palettes, row counts and row lengths close to the limits, so that both the valid and the invalid sides of each rule are reached.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int IMG_BYTES  = 64;
  localparam int WORD_BYTES = 4;
  localparam int IMG_WORDS  = IMG_BYTES / WORD_BYTES;
  localparam int PAL_OFS    = 0;
  localparam int BPR_OFS    = 16;
  localparam int ROWS_OFS   = 48;
  localparam logic [7:0] PAL_ACTIVE = 8'd1;

  typedef logic [IMG_BYTES-1:0][7:0] image_t;

  // Whether byte b carries a field for a bank of n tiles.
  function automatic bit is_field_byte(input int b, input int n);
    if (b == PAL_OFS) return 1'b1;
    if (b >= BPR_OFS && b < BPR_OFS + 2 * n) return 1'b1;
    if (b >= ROWS_OFS && b < ROWS_OFS + n) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] bpr_field(input image_t img, input int t);
    return {img[BPR_OFS + 2 * t + 1], img[BPR_OFS + 2 * t]};
  endfunction

  function automatic logic [7:0] rows_field(input image_t img, input int t);
    return img[ROWS_OFS + t];
  endfunction
endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage
  import tcfg_pkg::*;
#(
  parameter int ADDR_W = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output image_t            img
);
  localparam int LANE_W = $clog2(WORD_BYTES);

  for (genvar b = 0; b < IMG_BYTES; b++) begin : g_byte
    logic [7:0] q;
    logic hit_byte, hit_word;
    assign hit_byte = wr_en && !wr_wide && (wr_addr == ADDR_W'(b));
    assign hit_word = wr_en && wr_wide &&
                      (wr_addr[ADDR_W-1:LANE_W] == (ADDR_W-LANE_W)'(b / WORD_BYTES));
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= '0;
      else if (hit_byte) q <= wr_data[7:0];
      else if (hit_word) q <= wr_data[8*(b % WORD_BYTES) +: 8];
    end
    assign img[b] = q;
  end
endmodule

// File: rtl/tcfg_check.sv
module tcfg_check
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64
) (
  input  image_t img,
  output logic   is_init,
  output logic   is_ok,
  output logic   err_palette,
  output logic   err_reserved,
  output logic   err_range
);
  logic [IMG_BYTES-1:0] res_bad;
  logic [NUM_TILES-1:0] rng_bad;

  for (genvar b = 0; b < IMG_BYTES; b++) begin : g_res
    if (is_field_byte(b, NUM_TILES)) begin : g_fld
      assign res_bad[b] = 1'b0;
    end else begin : g_rsv
      assign res_bad[b] = |img[b];
    end
  end

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_rng
    assign rng_bad[t] = (int'(rows_field(img, t)) > MAX_ROWS) ||
                        (int'(bpr_field(img, t)) > MAX_BPR);
  end

  always_comb begin
    is_init      = (img[PAL_OFS] == 8'd0);
    err_palette  = !is_init && (img[PAL_OFS] != PAL_ACTIVE);
    err_reserved = !is_init && (|res_bad);
    err_range    = !is_init && (|rng_bad);
    is_ok        = !is_init && !err_palette && !err_reserved && !err_range;
  end
endmodule

// File: rtl/tcfg_state.sv
module tcfg_state
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64,
  parameter int ROW_W     = $clog2(MAX_ROWS + 1),
  parameter int BPR_W     = $clog2(MAX_BPR + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit,
  input  logic                               release_req,
  input  image_t                             img,
  input  logic                               chk_init,
  input  logic                               chk_ok,
  output logic                               configured,
  output logic [NUM_TILES-1:0][ROW_W-1:0]    rows_q,
  output logic [NUM_TILES-1:0][BPR_W-1:0]    bpr_q,
  output logic                               zero_all,
  output logic                               fault,
  output logic                               load_ok
);
  logic ev_release, ev_init, ev_accept, ev_fault;
  logic [NUM_TILES-1:0][ROW_W-1:0] rows_new;
  logic [NUM_TILES-1:0][BPR_W-1:0] bpr_new;
  logic [NUM_TILES-1:0] in_range;

  assign ev_release = release_req;
  assign ev_init    = !release_req && commit && chk_init;
  assign ev_accept  = !release_req && commit && chk_ok;
  assign ev_fault   = !release_req && commit && !chk_init && !chk_ok;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_shape
    assign rows_new[t] = rows_field(img, t)[ROW_W-1:0];
    assign bpr_new[t]  = bpr_field(img, t)[BPR_W-1:0];
    assign in_range[t] = (int'(rows_q[t]) <= MAX_ROWS) && (int'(bpr_q[t]) <= MAX_BPR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      configured <= 1'b0;
      rows_q     <= '0;
      bpr_q      <= '0;
      zero_all   <= 1'b0;
      fault      <= 1'b0;
      load_ok    <= 1'b0;
    end else begin
      zero_all <= ev_release || ev_init;
      fault    <= ev_fault;
      load_ok  <= ev_accept;
      if (ev_release || ev_init) begin
        configured <= 1'b0;
        rows_q     <= '0;
        bpr_q      <= '0;
      end else if (ev_accept) begin
        configured <= 1'b1;
        rows_q     <= rows_new;
        bpr_q      <= bpr_new;
      end
    end
  end

  AST_FAULT_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(configured) && $stable(rows_q) && $stable(bpr_q)); // R7
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault, load_ok, zero_all})); // R12
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_all |-> !configured && rows_q == '0 && bpr_q == '0); // R8
  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> configured); // R3
  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> !configured && zero_all && !load_ok); // R9
  AST_SHAPE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    configured |-> &in_range); // R6
endmodule

// File: rtl/tcfg_readback.sv
module tcfg_readback
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int ROW_W     = 5,
  parameter int BPR_W     = 7,
  parameter int WSEL_W    = $clog2(IMG_WORDS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            configured,
  input  logic [NUM_TILES-1:0][ROW_W-1:0] rows_q,
  input  logic [NUM_TILES-1:0][BPR_W-1:0] bpr_q,
  input  logic                            rd_req,
  input  logic [WSEL_W-1:0]               rd_word,
  output logic                            rd_valid,
  output logic [31:0]                     rd_data
);
  image_t view;
  logic [IMG_BYTES*8-1:0] view_flat;

  for (genvar b = 0; b < IMG_BYTES; b++) begin : g_view
    if (b == PAL_OFS) begin : g_pal
      assign view[b] = configured ? PAL_ACTIVE : 8'd0;
    end else if (b >= BPR_OFS && b < BPR_OFS + 2 * NUM_TILES) begin : g_bpr
      logic [15:0] wide;
      assign wide    = 16'(bpr_q[(b - BPR_OFS) / 2]);
      assign view[b] = wide[8*((b - BPR_OFS) % 2) +: 8];
    end else if (b >= ROWS_OFS && b < ROWS_OFS + NUM_TILES) begin : g_rows
      assign view[b] = 8'(rows_q[b - ROWS_OFS]);
    end else begin : g_zero
      assign view[b] = 8'd0;
    end
  end

  assign view_flat = view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? view_flat[32*rd_word +: 32] : 32'd0;
    end
  end

  AST_UNCONF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !$past(configured) |-> rd_data == 32'd0); // R10
endmodule

// File: rtl/tcfg_ctrl.sv
module tcfg_ctrl
  import tcfg_pkg::*;
#(
  parameter int NUM_TILES = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64,
  parameter int ROW_W     = $clog2(MAX_ROWS + 1),
  parameter int BPR_W     = $clog2(MAX_BPR + 1),
  parameter int ADDR_W    = $clog2(IMG_BYTES),
  parameter int WSEL_W    = $clog2(IMG_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_wide,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       commit,
  input  logic                       release_req,
  input  logic                       rd_req,
  input  logic [WSEL_W-1:0]          rd_word,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  output logic                       configured,
  output logic [NUM_TILES*ROW_W-1:0] tile_rows,
  output logic [NUM_TILES*BPR_W-1:0] tile_bpr,
  output logic [NUM_TILES-1:0]       tile_used,
  output logic                       zero_all,
  output logic                       fault,
  output logic                       load_ok
);
  image_t stage_img;
  logic chk_init, chk_ok, err_palette, err_reserved, err_range;
  logic [NUM_TILES-1:0][ROW_W-1:0] rows_q;
  logic [NUM_TILES-1:0][BPR_W-1:0] bpr_q;

  tcfg_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .img(stage_img)
  );

  tcfg_check #(.NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR)) u_check (
    .img(stage_img), .is_init(chk_init), .is_ok(chk_ok),
    .err_palette(err_palette), .err_reserved(err_reserved), .err_range(err_range)
  );

  tcfg_state #(.NUM_TILES(NUM_TILES), .MAX_ROWS(MAX_ROWS), .MAX_BPR(MAX_BPR),
               .ROW_W(ROW_W), .BPR_W(BPR_W)) u_state (
    .clk(clk), .rst_n(rst_n), .commit(commit), .release_req(release_req),
    .img(stage_img), .chk_init(chk_init), .chk_ok(chk_ok),
    .configured(configured), .rows_q(rows_q), .bpr_q(bpr_q),
    .zero_all(zero_all), .fault(fault), .load_ok(load_ok)
  );

  tcfg_readback #(.NUM_TILES(NUM_TILES), .ROW_W(ROW_W), .BPR_W(BPR_W),
                  .WSEL_W(WSEL_W)) u_rdbk (
    .clk(clk), .rst_n(rst_n), .configured(configured), .rows_q(rows_q),
    .bpr_q(bpr_q), .rd_req(rd_req), .rd_word(rd_word),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign tile_rows = rows_q;
  assign tile_bpr  = bpr_q;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_used
    assign tile_used[t] = configured && (|rows_q[t]) && (|bpr_q[t]);
  end

  AST_USED_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (|tile_used) |-> configured); // R11
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !release_req && (err_palette || err_reserved || err_range) |=> fault); // R4
  AST_BAD_PALETTE: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !release_req && err_palette |=> !load_ok && !zero_all); // R5
endmodule

// File: tb/tcfg_ctrl_test.sv
module tcfg_ctrl_test;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_wide = 1'b0, commit = 1'b0, release_req = 1'b0, rd_req = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_word = '0;
  logic rd_valid, configured, zero_all, fault, load_ok;
  logic [31:0] rd_data;
  logic [NT*5-1:0] tile_rows;
  logic [NT*7-1:0] tile_bpr;
  logic [NT-1:0] tile_used;

  tcfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .release_req(release_req), .rd_req(rd_req),
    .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data), .configured(configured),
    .tile_rows(tile_rows), .tile_bpr(tile_bpr), .tile_used(tile_used),
    .zero_all(zero_all), .fault(fault), .load_ok(load_ok)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sbuf [64];
  bit ecfg = 0;
  int erows [NT];
  int ebpr [NT];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 = init, 1 = accepted, 2 = fault
  function automatic int classify();
    if (sbuf[0] == 8'd0) return 0;
    if (sbuf[0] != 8'd1) return 2;
    for (int b = 1; b < 64; b++) begin
      bit fld = (b >= 16 && b < 32) || (b >= 48 && b < 56);
      if (!fld && sbuf[b] != 0) return 2;
    end
    for (int t = 0; t < NT; t++) begin
      if (sbuf[48+t] > 16) return 2;
      if ({sbuf[17+2*t], sbuf[16+2*t]} > 64) return 2;
    end
    return 1;
  endfunction

  function automatic logic [7:0] exp_byte(input int b);
    if (!ecfg) return 8'd0;
    if (b == 0) return 8'd1;
    if (b >= 16 && b < 32) return 8'((ebpr[(b-16)/2] >> (8*((b-16)%2))) & 255);
    if (b >= 48 && b < 56) return 8'(erows[b-48]);
    return 8'd0;
  endfunction

  task automatic wbyte(input int a, input logic [7:0] d);
    wr_en = 1; wr_wide = 0; wr_addr = 6'(a); wr_data = {24'hA5A5A5, d};
    @(negedge clk);
    wr_en = 0;
    sbuf[a] = d;
  endtask

  task automatic wword(input int a, input logic [31:0] d);
    wr_en = 1; wr_wide = 1; wr_addr = 6'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    for (int k = 0; k < 4; k++) sbuf[(a & 60) + k] = d[8*k +: 8];
  endtask

  task automatic load_image(input logic [7:0] img [64], input bit bytewise);
    for (int w = 0; w < 16; w++) begin
      if (bytewise) for (int k = 0; k < 4; k++) wbyte(4*w + k, img[4*w+k]);
      else wword(4*w + (w % 4), {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]});
    end
  endtask

  task automatic check_state(input string req);
    chk(configured == ecfg, req, configured, ecfg);
    for (int t = 0; t < NT; t++) begin
      bit u = ecfg && erows[t] != 0 && ebpr[t] != 0;
      chk(int'(tile_rows[5*t +: 5]) == erows[t], req, tile_rows[5*t +: 5], erows[t]);
      chk(int'(tile_bpr[7*t +: 7]) == ebpr[t], req, tile_bpr[7*t +: 7], ebpr[t]);
      chk(tile_used[t] == u, "R11", tile_used[t], u);
    end
  endtask

  task automatic read_all(input string req);
    for (int w = 0; w < 16; w++) begin
      logic [31:0] e;
      e = {exp_byte(4*w+3), exp_byte(4*w+2), exp_byte(4*w+1), exp_byte(4*w)};
      rd_req = 1; rd_word = 4'(w);
      @(negedge clk);
      rd_req = 0;
      chk(rd_valid == 1'b1, req, rd_valid, 1);
      chk(rd_data == e, req, rd_data, e);
    end
  endtask

  task automatic do_commit(input bit with_rel);
    int cls;
    string tag;
    cls = with_rel ? 0 : classify();
    tag = with_rel ? "R9" : (cls == 0 ? "R8" : (cls == 1 ? "R3" : "R7"));
    commit = 1; release_req = with_rel;
    @(negedge clk);
    commit = 0; release_req = 0;
    chk(zero_all == (cls == 0), tag, zero_all, cls == 0);
    chk(load_ok == (cls == 1), tag, load_ok, cls == 1);
    chk(fault == (cls == 2), tag, fault, cls == 2);
    if (cls == 0) begin
      ecfg = 0;
      for (int t = 0; t < NT; t++) begin erows[t] = 0; ebpr[t] = 0; end
    end else if (cls == 1) begin
      ecfg = 1;
      for (int t = 0; t < NT; t++) begin
        erows[t] = sbuf[48+t];
        ebpr[t] = {sbuf[17+2*t], sbuf[16+2*t]};
      end
    end
    check_state(tag);
    @(negedge clk);
    chk(!zero_all && !load_ok && !fault, "R12", {zero_all, load_ok, fault}, 0);
  endtask

  task automatic make_valid(output logic [7:0] img [64]);
    for (int b = 0; b < 64; b++) img[b] = 0;
    img[0] = 1;
    for (int t = 0; t < NT; t++) begin
      img[48+t] = 8'($urandom_range(0, 16));
      img[16+2*t] = 8'($urandom_range(0, 64));
    end
  endtask

  initial begin
    logic [7:0] img [64];
    void'($urandom(32'd4242));
    for (int b = 0; b < 64; b++) sbuf[b] = 0;
    for (int t = 0; t < NT; t++) begin erows[t] = 0; ebpr[t] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check_state("R1");
    chk(!zero_all && !fault && !load_ok, "R1", {zero_all, fault, load_ok}, 0);
    read_all("R10");

    // R2/R3: directed byte writes, then a word write with odd low address bits
    make_valid(img);
    img[48] = 16; img[16] = 64; img[49] = 0; img[18] = 5;
    load_image(img, 1'b1);
    do_commit(0);
    read_all("R10");
    wword(18, 32'h0007_0009);  // lands at bytes 16..19: tile0 bpr 9, tile1 bpr 7
    do_commit(0);
    chk(int'(tile_bpr[6:0]) == 9, "R2", tile_bpr[6:0], 9);
    chk(int'(tile_bpr[13:7]) == 7, "R2", tile_bpr[13:7], 7);

    // R4: reserved byte, state must hold (R7)
    wbyte(40, 8'h01); do_commit(0); read_all("R7"); wbyte(40, 8'h00);
    // R5: bad palette
    wbyte(0, 8'h02); do_commit(0); wbyte(0, 8'hFF); do_commit(0); wbyte(0, 8'h01);
    // R6: range limits, just over
    wbyte(50, 8'd17); do_commit(0); wbyte(50, 8'd16);
    wbyte(21, 8'h01); do_commit(0); wbyte(21, 8'h00);
    wbyte(20, 8'd65); do_commit(0); wbyte(20, 8'd64);
    do_commit(0);
    read_all("R6");
    // R8: palette 0 with garbage elsewhere
    wbyte(0, 8'h00); wbyte(40, 8'h77); wbyte(50, 8'd99);
    do_commit(0);
    read_all("R10");
    // R9: release alone and release together with a valid commit
    make_valid(img); load_image(img, 1'b0); do_commit(0);
    release_req = 1; @(negedge clk); release_req = 0;
    chk(zero_all == 1'b1, "R9", zero_all, 1);
    ecfg = 0;
    for (int t = 0; t < NT; t++) begin erows[t] = 0; ebpr[t] = 0; end
    check_state("R9");
    @(negedge clk);
    do_commit(0);
    do_commit(1);
    read_all("R9");

    // Random images near the limits
    for (int it = 0; it < 150; it++) begin
      int kind;
      make_valid(img);
      kind = $urandom_range(0, 9);
      if (kind == 0) img[0] = 0;
      else if (kind == 1) img[0] = 8'($urandom_range(2, 255));
      else if (kind == 2) img[$urandom_range(1, 15)] = 8'($urandom_range(1, 255));
      else if (kind == 3) img[48 + $urandom_range(0, NT-1)] = 8'($urandom_range(17, 20));
      else if (kind == 4) img[16 + 2*$urandom_range(0, NT-1)] = 8'($urandom_range(65, 70));
      else if (kind == 5) img[56 + $urandom_range(0, 7)] = 8'($urandom_range(1, 255));
      load_image(img, it % 3 == 0);
      do_commit(it % 17 == 16);
      if (it % 5 == 0) read_all("R10");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule